// File: doc/BRIEF.md
# Countdown Timer with Power-of-Two Prescaler

The block is a reloadable down-counter that raises a tick each time its count sits at zero. A prescaler in front of the counter divides the enabled clock by a power of two. The division is selected by a small exponent input, so an exponent of `e` gives a divisor of 2^e. When the count is zero the counter takes a fresh value from the load input. A user therefore sets the tick spacing with two inputs: the load value gives the coarse number of steps, and the exponent gives the length of each step.

The prescaler is cleared while the count is zero. Every reload therefore begins a full prescaled step, and the reload edge itself is never divided. With the enable held high, one full period takes `1 + load * 2^exponent` clocks. A load value of zero keeps the tick high. Both registers freeze while the enable is low, and a synchronous active-low reset clears them.

Top module: `pow2_countdown_timer`

## Requirements
- R1: On a clock edge with `rst_n` low, the count and the prescaler are cleared, whatever `en` is. `tick` is therefore 1 right after reset.
- R2: On an enabled edge while `tick` is 1 (count zero), the count takes `d_in` and the prescaler is set to 0.
- R3: With `d_in` = 0 and `en` high, `tick` stays at 1 on every cycle.
- R4: With `en` held high and constant inputs, successive cycles with `tick` at 1 are exactly `1 + d_in * 2^ps` clocks apart. This holds for every `ps`, including its maximum value (3 at the default width).
- R5: While `en` is low, the count and the prescaler hold their values, so `tick` does not change. Only enabled clocks count toward the period.
- R6: With `ps` = 0, a nonzero count decrements on every enabled edge.
- R7: A change of `ps` takes effect at the next prescaler comparison. A prescaler value above the new limit `2^ps - 1` counts up until it wraps at its register width, and the count decrements on that wrap.
- R8: `tick` is 1 exactly when the count is zero. It depends on no input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables the count and prescaler updates |
| d_in | input | CNT_W | Reload value taken when the count is zero |
| ps | input | EXP_W | Prescaler exponent; divisor is 2^ps |
| tick | output | 1 | High while the count is zero |

## Verification
The checker tests these rules on every cycle:
- the reload value and the prescaler clear after each zero state;
- the freeze of both registers while `en` is low;
- the clearing by reset;
- that a nonzero count moves by at most one per edge;
- the divide-by-one decrement when `ps` is 0.

The whole period length `1 + d_in * 2^ps` can only be shown by the bench, because it builds up over many cycles. The bench measures it for several load and exponent pairs, including a zero load and the largest exponent. It also tests two longer sequences: a `ps` change in the middle of a step, where the prescaler counts up to its wrap, and a period stretched by enable gaps.

// File: rtl/pow2_timer_pkg.sv
// Package: pow2_timer_pkg
// Shared sizing helpers for the power-of-two prescaled countdown timer.
// Assumes an exponent width of at least 1 bit.
package pow2_timer_pkg;

    // Prescaler register width: enough bits to reach 2^(max exponent) - 1.
    function automatic int pre_width(input int exp_w);
        return (1 << exp_w) - 1;
    endfunction

endpackage

// File: rtl/pt_zero_detect.sv
// Module: pt_zero_detect
// Flags a count of zero. The output is purely combinational on the
// registered count, so it carries no input-to-output path.
module pt_zero_detect #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    output logic             is_zero
);

    // Compare the registered count against zero.
    always_comb begin
        is_zero = (count == '0);
    end

endmodule

// File: rtl/pt_prescaler.sv
// Module: pt_prescaler
// Up-counting clock divider with a limit of 2^exp - 1. It is cleared
// while the main count is zero. wrap_next is high when the next value
// is zero, which is the moment the main count may step.
// Assumes EXP_W >= 1; the register wraps naturally at its own width.
module pt_prescaler
    import pow2_timer_pkg::*;
#(
    parameter int EXP_W = 2,
    localparam int PRE_W = pre_width(EXP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [EXP_W-1:0] exp_sel,
    input  logic             cnt_zero,
    output logic [PRE_W-1:0] pre_q,
    output logic             wrap_next
);

    logic [PRE_W:0]   limit_w;
    logic [PRE_W-1:0] pre_d;

    // Limit 2^exp - 1, one bit wider so the shift cannot overflow.
    always_comb begin
        limit_w = ({{PRE_W{1'b0}}, 1'b1} << exp_sel) - {{PRE_W{1'b0}}, 1'b1};
    end

    // Next prescaler value: clear on limit or on a zero count, else increment.
    always_comb begin
        if (({1'b0, pre_q} == limit_w) || cnt_zero) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
        end
        wrap_next = (pre_d == '0);
    end

    // Prescaler register: synchronous reset, update only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (en) begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/pt_down_counter.sv
// Module: pt_down_counter
// Main countdown register. It reloads from the load value when it is
// zero and decrements on a prescaler wrap. Otherwise it holds.
// Assumes wrap_next and cnt_zero come from the same cycle's state.
module pt_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cnt_zero,
    input  logic             wrap_next,
    output logic [CNT_W-1:0] cnt_q
);

    logic [CNT_W-1:0] cnt_d;

    // Next count: reload at zero, step down on wrap, otherwise hold.
    always_comb begin
        if (cnt_zero) begin
            cnt_d = load_val;
        end else if (wrap_next) begin
            cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
            cnt_d = cnt_q;
        end
    end

    // Count register: synchronous reset, update only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pow2_countdown_timer.sv
// Module: pow2_countdown_timer
// Top of the reloadable countdown timer with a power-of-two prescaler.
// tick is high while the count is zero. One full period with en held
// high is 1 + d_in * 2^ps clocks. Reset is synchronous and active low.
module pow2_countdown_timer
    import pow2_timer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int EXP_W = 2,
    localparam int PRE_W = pre_width(EXP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] d_in,
    input  logic [EXP_W-1:0] ps,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             cnt_zero;
    logic             wrap_next;

    pt_zero_detect #(.CNT_W(CNT_W)) u_zero (
        .count   (cnt_q),
        .is_zero (cnt_zero)
    );

    pt_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .exp_sel   (ps),
        .cnt_zero  (cnt_zero),
        .pre_q     (pre_q),
        .wrap_next (wrap_next)
    );

    pt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .load_val  (d_in),
        .cnt_zero  (cnt_zero),
        .wrap_next (wrap_next),
        .cnt_q     (cnt_q)
    );

    // Output tick straight from the zero flag.
    always_comb begin
        tick = cnt_zero;
    end

endmodule

// File: rtl/pow2_countdown_timer_chk.sv
// Module: pow2_countdown_timer_chk
// Cycle-level property checker for the countdown timer. It is bound
// into the top and observes the count and prescaler registers.
module pow2_countdown_timer_chk
    import pow2_timer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int EXP_W = 2,
    localparam int PRE_W = pre_width(EXP_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] d_in,
    input logic [EXP_W-1:0] ps,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [PRE_W-1:0] pre_q
);

    // R1: reset clears both registers, so tick is raised.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (tick && pre_q == '0 && cnt_q == '0));

    // R2: a zero state reloads from d_in and clears the prescaler.
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> (cnt_q == $past(d_in) && pre_q == '0));

    // R5: with en low, both registers hold.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cnt_q) && $stable(pre_q)));

    // R4: a nonzero count either holds or steps down by exactly one.
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> (cnt_q == $past(cnt_q) ||
                           cnt_q == CNT_W'($past(cnt_q) - 1)));

    // R6: with exponent zero, a nonzero count decrements every enabled edge.
    a_r6_div_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && ps == '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1)));

endmodule

bind pow2_countdown_timer pow2_countdown_timer_chk #(
    .CNT_W(CNT_W),
    .EXP_W(EXP_W)
) u_chk (.*);

// File: tb/test_pow2_countdown_timer.sv
// Bench for pow2_countdown_timer. A behavioural integer model advances
// on each edge and is compared with tick at every falling edge. Period
// measurements check the spacing rule directly.
module test_pow2_countdown_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int EXP_W = 2;
    localparam int PRE_MOD = 1 << ((1 << EXP_W) - 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [CNT_W-1:0] d_in = '0;
    logic [EXP_W-1:0] ps = '0;
    logic             tick;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    int m_pre = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    pow2_countdown_timer #(.CNT_W(CNT_W), .EXP_W(EXP_W)) i_pow2_countdown_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .d_in(d_in), .ps(ps), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check and print a FAIL line on a mismatch.
    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // One clock: drive inputs, advance the model at the edge, compare at negedge.
    task automatic step(input bit r, input bit e, input int d, input int p);
        int lim, pn, cn;
        rst_n = r; en = e; d_in = CNT_W'(d); ps = EXP_W'(p);
        @(posedge clk);
        if (!r) begin
            m_cnt = 0; m_pre = 0;
        end else if (e) begin
            lim = (1 << p) - 1;
            pn = (m_pre == lim || m_cnt == 0) ? 0 : (m_pre + 1) % PRE_MOD;
            cn = (m_cnt == 0) ? d : ((pn == 0) ? m_cnt - 1 : m_cnt);
            m_pre = pn; m_cnt = cn;
        end
        @(negedge clk);
        check(cur_req, int'(tick), (m_cnt == 0) ? 1 : 0);
    endtask

    // Wait for tick, then count enabled clocks until the next tick.
    task automatic measure(input int d, input int p, output int n);
        n = 0;
        for (int k = 0; k < 3000 && !tick; k++) step(1, 1, d, p);
        for (int k = 0; k < 3000; k++) begin
            step(1, 1, d, p);
            n++;
            if (tick) break;
        end
    endtask

    initial begin
        int n;
        @(negedge clk);
        cur_req = "R1";
        step(0, 0, 0, 0);
        check("R1", int'(tick), 1);
        step(1, 1, 5, 0);

        cur_req = "R6";
        measure(5, 0, n);
        check("R6", n, 6);

        cur_req = "R4";
        measure(3, 1, n); check("R4", n, 1 + 3 * 2);
        measure(10, 2, n); check("R4", n, 1 + 10 * 4);
        measure(2, 3, n); check("R4", n, 1 + 2 * 8);
        measure(255, 3, n); check("R4", n, 1 + 255 * 8);

        cur_req = "R3";
        measure(0, 2, n); check("R3", n, 1);
        for (int k = 0; k < 10; k++) begin
            step(1, 1, 0, 3);
            check("R3", int'(tick), 1);
        end

        // R2: each zero state lasts exactly one enabled clock.
        cur_req = "R2";
        measure(1, 0, n); check("R2", n, 2);
        step(1, 1, 1, 0); check("R2", int'(tick), 0);

        // R5: gaps in en freeze the count and stretch wall time only.
        cur_req = "R5";
        measure(4, 1, n);
        n = 0;
        for (int k = 0; k < 3; k++) begin step(1, 1, 4, 1); n++; end
        for (int k = 0; k < 7; k++) begin
            step(1, 0, 0, 3);
            check("R5", int'(tick), 0);
        end
        for (int k = 0; k < 100; k++) begin
            step(1, 1, 4, 1); n++;
            if (tick) break;
        end
        check("R5", n, 1 + 4 * 2);

        // R7: exponent drops while the prescaler sits above the new limit.
        cur_req = "R7";
        measure(4, 3, n);
        step(1, 1, 4, 3);
        for (int k = 0; k < 6; k++) step(1, 1, 4, 3);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            step(1, 1, 4, 1); n++;
            if (tick) break;
        end
        check("R7", n, 2 + 3 * 2);

        // R1: reset mid-count with en low still clears.
        cur_req = "R1";
        measure(9, 2, n);
        for (int k = 0; k < 5; k++) step(1, 1, 9, 2);
        step(0, 0, 9, 2);
        check("R1", int'(tick), 1);

        // R8: tick follows the count only, not d_in in the same cycle.
        cur_req = "R8";
        step(1, 0, 0, 0);
        d_in = 8'd77; #1;
        check("R8", int'(tick), 1);
        step(1, 1, 6, 0);
        d_in = 8'd0; #1;
        check("R8", int'(tick), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule